// File: doc/BRIEF.md
# Signed Gene-Order Breakpoint Counter

This block measures how far apart two signed gene orders of the same length are. It counts the adjacencies of the first order, A, that the second order, B, does not keep. A signed gene is a gene identifier with an orientation. Two neighbouring genes g then h in A are kept when B holds g directly followed by h. They are also kept when B holds -h directly followed by -g, which is the same stretch of chromosome read on the opposite strand. Every adjacency of A that B does not keep adds one to the count.

A run opens with a one-cycle `start`. The genes of B are then streamed in order, one per valid cycle. While B streams in, the block fills a successor table indexed by signed gene. Each B pair (x,y) writes two entries: successor of x is y, and successor of -y is -x. The genes of A follow, one per valid cycle, with `a_last` marking the final gene. Each A adjacency is resolved by one table lookup in the cycle its second gene arrives. One cycle after the last A gene, `done` pulses and `bp_count` holds the distance. The count then stays put until the next `start`. The parameter `WRAP` chooses between a linear genome and a circular one. In the circular case the last-to-first adjacency of both orders is included.

Top module: `breakpoint_counter`

## Requirements
- R1: A gene word is MAG_W+1 bits wide. The top bit is the orientation (1 means reversed, that is, negative) and the low MAG_W bits are the gene magnitude.
- R2: A `start` pulse clears `bp_count` to 0 on the following cycle, and `done` is low on that cycle.
- R3: An adjacency (g,h) of A adds nothing to the count when B holds g immediately followed by h.
- R4: An adjacency (g,h) of A adds nothing to the count when B holds -h immediately followed by -g.
- R5: Every other adjacency of A adds one. For A = 1 2 3 4 5 and B = -2 -1 -5 -4 3 with WRAP=0, the result is 2.
- R6: `done` is high for exactly the one cycle after the cycle in which the A gene flagged by `a_last` is accepted. On that cycle `bp_count` already holds the final distance.
- R7: After `done`, `bp_count` keeps its value until the next `start`. The count never goes down within a run.
- R8: With WRAP=1, the pair (last A gene, first A gene) is also checked, and B's last-to-first pair also counts as a B adjacency. With WRAP=0, neither is used.
- R9: A gene is taken only on a cycle where its valid input is high, and idle cycles may fall anywhere between genes without changing the result.
- R10: After reset, `bp_count` is 0 and `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a new comparison; clears table and count |
| b_valid | input | 1 | `b_gene` carries the next gene of B |
| b_gene | input | MAG_W+1 | Signed gene of B: {reversed, magnitude} |
| a_valid | input | 1 | `a_gene` carries the next gene of A |
| a_gene | input | MAG_W+1 | Signed gene of A: {reversed, magnitude} |
| a_last | input | 1 | Marks the final gene of A, qualified by `a_valid` |
| bp_count | output | $clog2(MAX_GENES+1) | Breakpoint distance of the last run |
| done | output | 1 | One-cycle pulse when `bp_count` is final |

## Verification
The embedded properties assume well-formed runs. Each run opens with `start` and then presents all of B before any A gene. No genome is longer than MAX_GENES, every genome holds each magnitude once with no repeats, and `a_last` comes exactly once per run. The bench keeps to these assumptions. It builds every genome as a shuffled set of the magnitudes 1..n with random orientations. It derives many B orders from A by reversing and negating random segments, so that kept adjacencies occur often. It always streams B completely before A, and inserts random idle cycles only between genes.

// File: rtl/breakpoint_counter.sv
module breakpoint_counter #(
  parameter int MAX_GENES = 32,
  parameter int MAG_W     = 6,
  parameter bit WRAP      = 1'b0
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic                               b_valid,
  input  logic [MAG_W:0]                     b_gene,
  input  logic                               a_valid,
  input  logic [MAG_W:0]                     a_gene,
  input  logic                               a_last,
  output logic [$clog2(MAX_GENES+1)-1:0]     bp_count,
  output logic                               done
);
  localparam int GW  = MAG_W + 1;
  localparam int TBL = 1 << GW;
  localparam int CW  = $clog2(MAX_GENES + 1);

  function automatic logic [GW-1:0] flip(input logic [GW-1:0] x);
    return {~x[GW-1], x[GW-2:0]};
  endfunction

  logic [GW-1:0]  succ [TBL];
  logic [TBL-1:0] sval;
  logic [GW-1:0]  b_prev, b_first, a_prev, a_first;
  logic           b_have, a_have;
  logic [CW-1:0]  cnt;

  wire hit_lin  = sval[a_prev]  && (succ[a_prev]  == a_gene);
  wire hit_wrap = sval[a_gene]  && (succ[a_gene]  == a_first);
  wire pair_bp  = a_valid && a_have && !hit_lin;
  wire wrap_bp  = WRAP && a_valid && a_last && !hit_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sval    <= '0;
      b_have  <= 1'b0;
      a_have  <= 1'b0;
      b_prev  <= '0;
      b_first <= '0;
      a_prev  <= '0;
      a_first <= '0;
      cnt     <= '0;
      done    <= 1'b0;
    end else if (start) begin
      sval   <= '0;
      b_have <= 1'b0;
      a_have <= 1'b0;
      cnt    <= '0;
      done   <= 1'b0;
    end else begin
      done <= a_valid && a_last;
      if (b_valid) begin
        b_prev <= b_gene;
        b_have <= 1'b1;
        if (!b_have) b_first <= b_gene;
        else begin
          succ[b_prev]       <= b_gene;
          sval[b_prev]       <= 1'b1;
          succ[flip(b_gene)] <= flip(b_prev);
          sval[flip(b_gene)] <= 1'b1;
        end
      end
      if (a_valid) begin
        a_prev <= a_gene;
        a_have <= 1'b1;
        if (!a_have) begin
          a_first <= a_gene;
          if (WRAP && b_have) begin
            succ[b_prev]        <= b_first;
            sval[b_prev]        <= 1'b1;
            succ[flip(b_first)] <= flip(b_prev);
            sval[flip(b_first)] <= 1'b1;
          end
        end
        cnt <= cnt + CW'(pair_bp) + CW'(wrap_bp);
      end
    end
  end

  assign bp_count = cnt;

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (bp_count == '0) && !done);

  a_r6_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_last && !start) |=> done);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done || $past(a_valid && a_last));

  a_r7_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !a_valid) |=> $stable(bp_count));

  a_r7_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> bp_count >= $past(bp_count));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    bp_count <= CW'(MAX_GENES));
endmodule

// File: tb/breakpoint_counter_bench.sv
`timescale 1ns/1ps
module breakpoint_counter_bench;
  localparam int MAXG = 32;
  localparam int MW   = 6;
  localparam int CW   = $clog2(MAXG + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic b_valid = 1'b0, a_valid = 1'b0, a_last = 1'b0;
  logic [MW:0] b_gene = '0, a_gene = '0;
  logic [CW-1:0] cnt0, cnt1;
  logic done0, done1;
  int total = 0, bad = 0;
  int ga[MAXG], gb[MAXG];

  always #5 clk = ~clk;

  breakpoint_counter #(.MAX_GENES(MAXG), .MAG_W(MW), .WRAP(1'b0)) u_breakpoint_counter (
    .clk(clk), .rst_n(rst_n), .start(start), .b_valid(b_valid), .b_gene(b_gene),
    .a_valid(a_valid), .a_gene(a_gene), .a_last(a_last), .bp_count(cnt0), .done(done0));

  breakpoint_counter #(.MAX_GENES(MAXG), .MAG_W(MW), .WRAP(1'b1)) u_breakpoint_counter_wrap (
    .clk(clk), .rst_n(rst_n), .start(start), .b_valid(b_valid), .b_gene(b_gene),
    .a_valid(a_valid), .a_gene(a_gene), .a_last(a_last), .bp_count(cnt1), .done(done1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1: sign bit on top, magnitude below
  function automatic logic [MW:0] enc(input int v);
    return (v < 0) ? {1'b1, MW'(-v)} : {1'b0, MW'(v)};
  endfunction

  function automatic bit kept(input int n, input bit wrap, input int g, input int h);
    int lim = wrap ? n : n - 1;
    for (int j = 0; j < lim; j++) begin
      int x = gb[j];
      int y = gb[(j + 1) % n];
      if ((x == g && y == h) || (x == -h && y == -g)) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic int ref_bp(input int n, input bit wrap);
    int c = 0;
    for (int i = 0; i < n - 1; i++) if (!kept(n, wrap, ga[i], ga[i+1])) c++;
    if (wrap && !kept(n, wrap, ga[n-1], ga[0])) c++;
    return c;
  endfunction

  task automatic rand_perm(input int n, output int g[MAXG]);
    for (int i = 0; i < n; i++) g[i] = i + 1;
    for (int i = n - 1; i > 0; i--) begin
      int j = $urandom_range(0, i);
      int t = g[i]; g[i] = g[j]; g[j] = t;
    end
    for (int i = 0; i < n; i++) if ($urandom_range(0, 1) == 1) g[i] = -g[i];
  endtask

  task automatic derive_b(input int n);
    for (int i = 0; i < n; i++) gb[i] = ga[i];
    for (int k = 0; k < $urandom_range(0, 3); k++) begin
      int lo = $urandom_range(0, n - 1);
      int hi = $urandom_range(lo, n - 1);
      while (lo < hi) begin
        int t = gb[lo]; gb[lo] = -gb[hi]; gb[hi] = -t; lo++; hi--;
      end
      if (lo == hi) gb[lo] = -gb[lo];
    end
  endtask

  task automatic run_case(input int n, input bit gaps, input string tag);
    int e0 = ref_bp(n, 1'b0);
    int e1 = ref_bp(n, 1'b1);
    int h0, h1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(cnt0 == 0 && !done0 && cnt1 == 0, {"R2 ", tag}, int'(cnt0), 0);
    for (int i = 0; i < n; i++) begin
      if (gaps && $urandom_range(0, 2) == 0) @(negedge clk);
      b_valid = 1'b1; b_gene = enc(gb[i]);
      @(negedge clk) b_valid = 1'b0; b_gene = '0;
    end
    for (int i = 0; i < n; i++) begin
      if (gaps && $urandom_range(0, 2) == 0) @(negedge clk);
      a_valid = 1'b1; a_gene = enc(ga[i]); a_last = (i == n - 1);
      @(negedge clk) a_valid = 1'b0; a_last = 1'b0; a_gene = '0;
    end
    chk(done0 && done1, {"R6 done ", tag}, int'(done0), 1);
    chk(int'(cnt0) == e0, {"R3 R4 R5 R9 linear ", tag}, int'(cnt0), e0);
    chk(int'(cnt1) == e1, {"R8 circular ", tag}, int'(cnt1), e1);
    h0 = int'(cnt0); h1 = int'(cnt1);
    repeat (2) @(negedge clk);
    chk(!done0 && !done1, {"R6 pulse ", tag}, int'(done0), 0);
    chk(int'(cnt0) == h0 && int'(cnt1) == h1, {"R7 hold ", tag}, int'(cnt0), h0);
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk(cnt0 == 0 && !done0 && cnt1 == 0 && !done1, "R10 reset", int'(cnt0), 0);
    rst_n = 1'b1;
    @(negedge clk);

    ga[0]=1; ga[1]=2; ga[2]=3; ga[3]=4; ga[4]=5;
    gb[0]=-2; gb[1]=-1; gb[2]=-5; gb[3]=-4; gb[4]=3;
    run_case(5, 1'b0, "example");
    chk(cnt0 == 2, "R5 R1 example", int'(cnt0), 2);
    chk(cnt1 == 2, "R8 example", int'(cnt1), 2);

    for (int i = 0; i < 8; i++) begin ga[i] = i + 1; gb[i] = i + 1; end
    run_case(8, 1'b1, "identity");
    chk(cnt0 == 0, "R3 identity", int'(cnt0), 0);

    for (int i = 0; i < 8; i++) gb[i] = -(8 - i);
    run_case(8, 1'b0, "reversed");
    chk(cnt0 == 0 && cnt1 == 0, "R4 reversed", int'(cnt0), 0);

    for (int i = 0; i < 6; i++) begin ga[i] = i + 1; gb[i] = ((i + 1) % 6) + 1; end
    run_case(6, 1'b0, "rotation");
    chk(cnt0 == 1 && cnt1 == 0, "R8 rotation", int'(cnt1), 0);

    for (int i = 0; i < MAXG; i++) ga[i] = (i % 2 == 0) ? i + 1 : -(i + 1);
    for (int i = 0; i < MAXG; i++) gb[i] = ga[MAXG - 1 - i];
    run_case(MAXG, 1'b1, "full reversal no negate");
    chk(cnt0 == MAXG - 1, "R5 full", int'(cnt0), MAXG - 1);

    for (int t = 0; t < 40; t++) begin
      int n = $urandom_range(2, MAXG);
      rand_perm(n, ga);
      if (t % 2 == 0) derive_b(n);
      else rand_perm(n, gb);
      run_case(n, t % 3 != 0, "random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule